// File: doc/BRIEF.md
# Four-Mode Microcontroller Serial Port

This block is a byte-wide serial port of the kind found beside a small 8-bit processor core. Software reaches it through two addresses: a control register and a data address. The control register holds the operating mode, a receive enable, the ninth bit for each direction and the two completion flags. The data address is backed by two separate registers. A write fills the transmit shifter and a read returns the last received byte.

There are four modes. Mode 0 is a synchronous shift mode. The port is always the clock master: it drives a shift clock on its transmit pin and moves data on the receive-data pin, so that pin has separate output, output-enable and input signals. Modes 1 to 3 are asynchronous framed modes with 8 or 9 data bits. Their receiver oversamples each bit 16 times and decides the bit by a majority vote. In modes 1 and 3 the oversample tick comes from an external timer-overflow pulse. In mode 2 it is derived from the system clock, so that one bit lasts 32 or 64 clocks.

Top module: `mcu_serial_port`

## Requirements
- R1: After reset the control register reads 0x00, the received-byte register reads 0x00, `txd` is high and `rxd_oe` is low.
- R2: Address 0 is the control register. Its bits are [7:6] mode (00 shift, 01 async 8-bit, 10 async 9-bit at a fixed rate, 11 async 9-bit at the timer rate), [5] reads 0, [4] receive enable, [3] transmit ninth bit, [2] receive ninth bit, [1] transmit flag and [0] receive flag. Address 1 is the data address. Writing a 0 to a flag bit clears that flag; writing a 1 leaves it unchanged.
- R3: Mode 0 transmit. A data write drives the 8 bits least significant first on `rxd_out` with `rxd_oe` high. `txd` carries a shift clock with a period of 12 clocks, low for the first half of each bit, and the data is stable at each rising edge. The transmit flag sets after the eighth bit.
- R4: Mode 0 receive. Reception starts while receive enable is 1 and the receive flag is 0. The port samples `rxd_in` at each rising edge of its shift clock, least significant bit first. After 8 bits it stores the byte and sets the receive flag. No further shift clock is produced while the flag stays set.
- R5: Mode 1 transmit frame. The frame is a 0 start bit, 8 data bits least significant first, and a 1 stop bit. Each bit lasts 16 ticks of `timer_tick`.
- R6: Modes 2 and 3 transmit frame. The frame is a start bit, 8 data bits, then the transmit ninth bit from control bit 3, then a 1 stop bit.
- R7: Asynchronous receive. A completed frame stores its data byte and sets the receive flag. The receive ninth bit takes the stop-bit value in mode 1 and the ninth data bit in modes 2 and 3.
- R8: In mode 2 a bit lasts 32 clocks when `rate_hi` is 1 and 64 clocks when it is 0.
- R9: While receive enable is 0, an incoming frame does not change the received byte or the receive flag.
- R10: A falling edge whose start bit reads 1 at mid-bit, by a vote of ticks 7, 8 and 9, is abandoned. The next valid frame is still received.
- R11: A frame that completes while the receive flag is set is dropped. The held byte and the receive ninth bit keep their values.
- R12: In modes 1 to 3, transmit and receive run at the same time. A data write never alters the byte that a data read returns.
- R13: In the asynchronous modes the transmit flag sets at the start of the stop bit, not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| timer_tick | input | 1 | Oversample tick from a timer overflow (modes 1 and 3) |
| rate_hi | input | 1 | Mode 2 rate select: 1 gives 32 clocks per bit, 0 gives 64 |
| rxd_in | input | 1 | Receive-data pin input |
| rxd_out | output | 1 | Receive-data pin output value (mode 0 transmit) |
| rxd_oe | output | 1 | Receive-data pin output enable |
| txd | output | 1 | Serial transmit line, or the shift clock in mode 0 |

## Verification
The hardest states to reach from the ports are a frame that ends while the receive flag is still set, and a start edge that turns out to be noise. The bench deliberately leaves the flag uncleared before it sends a second frame. It also drives a low pulse shorter than half a bit before a real frame. Mode 0 reception needs the bench to act as the slave: it follows the shift clock the port drives and presents a new bit on each falling edge. Full duplex is reached by running the transmit decoder and the receive driver as parallel branches.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_A8    = 2'b01,
    MODE_A9FIX = 2'b10,
    MODE_A9VAR = 2'b11
  } sp_mode_e;

  localparam int CB_REN = 4;
  localparam int CB_T9  = 3;
  localparam int CB_R9  = 2;
  localparam int CB_TF  = 1;
  localparam int CB_RF  = 0;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/sp_rate_gen.sv
module sp_rate_gen
  import sp_pkg::*;
#(
  parameter int DIV0 = 12
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sp_mode_e mode,
  input  logic     rate_hi,
  input  logic     timer_tick,
  input  logic     m0_restart,
  output logic     os_tick,
  output logic     m0_high,
  output logic     m0_rise,
  output logic     m0_end
);
  localparam int CW = $clog2(DIV0);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    div_q, div_d;

  always_comb begin
    if (m0_restart || cnt_q == CW'(DIV0-1)) cnt_d = '0;
    else                                    cnt_d = cnt_q + 1'b1;
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign m0_high = (cnt_q >= CW'(DIV0/2));
  assign m0_rise = (cnt_q == CW'(DIV0/2));
  assign m0_end  = (cnt_q == CW'(DIV0-1));
  assign os_tick = (mode == MODE_A9FIX) ? (rate_hi ? div_q[0] : &div_q) : timer_tick;
endmodule

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sp_mode_e      mode,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          bit9,
  input  logic          os_tick,
  input  logic          m0_end,
  output logic          line,
  output logic          busy,
  output logic          m0_act,
  output logic          done
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(FW);
  localparam int SW = $clog2(OVS);

  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] bit_q, bit_d, last_q, last_d;
  logic [SW-1:0] sub_q, sub_d;
  logic          busy_q, busy_d, m0_q, m0_d;

  always_comb begin
    sh_d = sh_q; bit_d = bit_q; last_d = last_q; sub_d = sub_q;
    busy_d = busy_q; m0_d = m0_q; done = 1'b0;
    if (load && !busy_q) begin
      busy_d = 1'b1; bit_d = '0; sub_d = '0;
      m0_d = (mode == MODE_SHIFT);
      if (mode == MODE_SHIFT) begin
        sh_d   = {{3{1'b1}}, din};
        last_d = CW'(DW-1);
      end else begin
        sh_d   = {1'b1, (mode == MODE_A8) ? 1'b1 : bit9, din, 1'b0};
        last_d = (mode == MODE_A8) ? CW'(DW+1) : CW'(DW+2);
      end
    end else if (busy_q) begin
      if (m0_q) begin
        if (m0_end) begin
          if (bit_q == last_q) begin
            busy_d = 1'b0; done = 1'b1;
          end else begin
            sh_d = {1'b1, sh_q[FW-1:1]}; bit_d = bit_q + 1'b1;
          end
        end
      end else if (os_tick) begin
        if (sub_q == SW'(OVS-1)) begin
          sub_d = '0;
          if (bit_q == last_q) busy_d = 1'b0;
          else begin
            sh_d  = {1'b1, sh_q[FW-1:1]};
            bit_d = bit_q + 1'b1;
            if (bit_q + 1'b1 == last_q) done = 1'b1;
          end
        end else begin
          sub_d = sub_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1; bit_q <= '0; last_q <= '0; sub_q <= '0;
      busy_q <= 1'b0; m0_q <= 1'b0;
    end else begin
      sh_q <= sh_d; bit_q <= bit_d; last_q <= last_d; sub_q <= sub_d;
      busy_q <= busy_d; m0_q <= m0_d;
    end
  end

  assign line   = busy_q ? sh_q[0] : 1'b1;
  assign busy   = busy_q;
  assign m0_act = busy_q & m0_q;
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sp_mode_e      mode,
  input  logic          ren,
  input  logic          flag,
  input  logic          tx_busy,
  input  logic          rxd,
  input  logic          os_tick,
  input  logic          m0_rise,
  input  logic          m0_end,
  output logic          busy,
  output logic          m0_act,
  output logic          m0_start,
  output logic          store,
  output logic          r9_we,
  output logic [DW-1:0] data,
  output logic          bit9
);
  localparam int CW  = $clog2(DW + 3);
  localparam int SW  = $clog2(OVS);
  localparam int MID = OVS / 2;

  logic [DW:0]   sh_q, sh_d;
  logic [CW-1:0] bit_q, bit_d, last;
  logic [SW-1:0] sub_q, sub_d;
  logic          busy_q, busy_d, m0_q, m0_d;
  logic          s7_q, s7_d, s8_q, s8_d, prev_q;
  logic          nine, vote, finish;

  assign nine = (mode == MODE_A9FIX) || (mode == MODE_A9VAR);
  assign last = nine ? CW'(DW+2) : CW'(DW+1);
  assign vote = (s7_q & s8_q) | (s7_q & rxd) | (s8_q & rxd);

  always_comb begin
    sh_d = sh_q; bit_d = bit_q; sub_d = sub_q; busy_d = busy_q; m0_d = m0_q;
    s7_d = s7_q; s8_d = s8_q; m0_start = 1'b0; finish = 1'b0;
    if (!busy_q) begin
      if (mode == MODE_SHIFT) begin
        if (ren && !flag && !tx_busy) begin
          busy_d = 1'b1; m0_d = 1'b1; bit_d = '0; m0_start = 1'b1;
        end
      end else if (ren && prev_q && !rxd) begin
        busy_d = 1'b1; m0_d = 1'b0; bit_d = '0; sub_d = '0;
      end
    end else if (m0_q) begin
      if (m0_rise) sh_d[DW-1:0] = {rxd, sh_q[DW-1:1]};
      if (m0_end) begin
        if (bit_q == CW'(DW-1)) begin
          busy_d = 1'b0; finish = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end else if (os_tick) begin
      sub_d = (sub_q == SW'(OVS-1)) ? '0 : sub_q + 1'b1;
      if (sub_q == SW'(OVS-1)) bit_d = bit_q + 1'b1;
      if (sub_q == SW'(MID-2)) s7_d = rxd;
      if (sub_q == SW'(MID-1)) s8_d = rxd;
      if (sub_q == SW'(MID)) begin
        if (bit_q == '0) begin
          if (vote) busy_d = 1'b0;
        end else if (bit_q <= CW'(DW)) begin
          sh_d[DW-1:0] = {vote, sh_q[DW-1:1]};
        end else if (bit_q != last) begin
          sh_d[DW] = vote;
        end else begin
          busy_d = 1'b0; finish = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; bit_q <= '0; sub_q <= '0; busy_q <= 1'b0; m0_q <= 1'b0;
      s7_q <= 1'b1; s8_q <= 1'b1; prev_q <= 1'b1;
    end else begin
      sh_q <= sh_d; bit_q <= bit_d; sub_q <= sub_d; busy_q <= busy_d; m0_q <= m0_d;
      s7_q <= s7_d; s8_q <= s8_d; prev_q <= rxd;
    end
  end

  assign busy   = busy_q;
  assign m0_act = busy_q & m0_q;
  assign store  = finish & !flag;
  assign r9_we  = store & !m0_q;
  assign data   = sh_q[DW-1:0];
  assign bit9   = nine ? sh_q[DW] : vote;
endmodule

// File: rtl/mcu_serial_port.sv
module mcu_serial_port
  import sp_pkg::*;
#(
  parameter int DW   = 8,
  parameter int OVS  = 16,
  parameter int DIV0 = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          timer_tick,
  input  logic          rate_hi,
  input  logic          rxd_in,
  output logic          rxd_out,
  output logic          rxd_oe,
  output logic          txd
);
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  sp_mode_e      mode_q, mode_d;
  logic          ren_q, ren_d, t9_q, t9_d, r9_q, r9_d, tf_q, tf_d, rf_q, rf_d;
  logic [DW-1:0] rxbuf_q, rxbuf_d;
  logic [1:0]    sync_q;
  logic          wr_ctrl, wr_data, tx_load, m0_restart;
  logic          os_tick, m0_high, m0_rise, m0_end;
  logic          tx_line, tx_busy, tx_m0, tx_done;
  logic          rx_busy, rx_m0, rx_m0_start, rx_store, rx_r9_we, rx_bit9;
  logic [DW-1:0] rx_data;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sync_q <= 2'b11;
    else            sync_q <= {sync_q[0], rxd_in};
  end

  assign wr_ctrl    = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_data    = bus_wr && (bus_addr == ADDR_DATA);
  assign tx_load    = wr_data && !rx_m0;
  assign m0_restart = (tx_load && !tx_busy && mode_q == MODE_SHIFT) || rx_m0_start;

  sp_rate_gen #(.DIV0(DIV0)) u_rate (
    .clk(clk), .rst_n(rst_int_n), .mode(mode_q), .rate_hi(rate_hi),
    .timer_tick(timer_tick), .m0_restart(m0_restart), .os_tick(os_tick),
    .m0_high(m0_high), .m0_rise(m0_rise), .m0_end(m0_end)
  );

  sp_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .mode(mode_q), .load(tx_load), .din(bus_wdata),
    .bit9(t9_q), .os_tick(os_tick), .m0_end(m0_end), .line(tx_line),
    .busy(tx_busy), .m0_act(tx_m0), .done(tx_done)
  );

  sp_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .mode(mode_q), .ren(ren_q), .flag(rf_q),
    .tx_busy(tx_busy), .rxd(sync_q[1]), .os_tick(os_tick), .m0_rise(m0_rise),
    .m0_end(m0_end), .busy(rx_busy), .m0_act(rx_m0), .m0_start(rx_m0_start),
    .store(rx_store), .r9_we(rx_r9_we), .data(rx_data), .bit9(rx_bit9)
  );

  always_comb begin
    mode_d = wr_ctrl ? sp_mode_e'(bus_wdata[7:6]) : mode_q;
    ren_d  = wr_ctrl ? bus_wdata[CB_REN] : ren_q;
    t9_d   = wr_ctrl ? bus_wdata[CB_T9]  : t9_q;
    if (rx_r9_we)     r9_d = rx_bit9;
    else if (wr_ctrl) r9_d = bus_wdata[CB_R9];
    else              r9_d = r9_q;
    if (tx_done)                         tf_d = 1'b1;
    else if (wr_ctrl && !bus_wdata[CB_TF]) tf_d = 1'b0;
    else                                 tf_d = tf_q;
    if (rx_store)                        rf_d = 1'b1;
    else if (wr_ctrl && !bus_wdata[CB_RF]) rf_d = 1'b0;
    else                                 rf_d = rf_q;
    rxbuf_d = rx_store ? rx_data : rxbuf_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= MODE_SHIFT; ren_q <= 1'b0; t9_q <= 1'b0; r9_q <= 1'b0;
      tf_q <= 1'b0; rf_q <= 1'b0; rxbuf_q <= '0;
    end else begin
      mode_q <= mode_d; ren_q <= ren_d; t9_q <= t9_d; r9_q <= r9_d;
      tf_q <= tf_d; rf_q <= rf_d; rxbuf_q <= rxbuf_d;
    end
  end

  assign bus_rdata = (bus_addr == ADDR_DATA) ? rxbuf_q
                   : DW'({mode_q, 1'b0, ren_q, t9_q, r9_q, tf_q, rf_q});
  assign txd     = (mode_q == MODE_SHIFT) ? ((tx_m0 || rx_m0) ? m0_high : 1'b1) : tx_line;
  assign rxd_out = tx_m0 ? tx_line : 1'b1;
  assign rxd_oe  = tx_m0;
endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       ren,
  input logic       txd,
  input logic       rflag,
  input logic       tflag,
  input logic [7:0] rxbuf,
  input logic       tx_busy,
  input logic       rx_busy,
  input logic       rx_m0
);
  assert_hold_on_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rflag |=> $stable(rxbuf));

  assert_stop_level_at_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tflag) && mode != 2'b00) |-> txd);

  assert_clock_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !txd) |-> (tx_busy || rx_busy));

  assert_half_duplex_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_m0 |-> !tx_busy);

  assert_idle_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren && !rx_busy) |=> !rx_busy);
endmodule

bind mcu_serial_port sp_checker u_sp_checker (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .ren(ren_q), .txd(txd),
  .rflag(rf_q), .tflag(tf_q), .rxbuf(rxbuf_q), .tx_busy(tx_busy),
  .rx_busy(rx_busy), .rx_m0(rx_m0)
);

// File: tb/test_mcu_serial_port.sv
module test_mcu_serial_port;
  localparam int TT = 3;
  localparam int BC = 16 * TT;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, bus_wr, bus_addr, timer_tick, rate_hi, rxd_in;
  logic [7:0] bus_wdata, bus_rdata;
  logic       rxd_out, rxd_oe, txd;
  int n_chk = 0, n_fail = 0;

  // behavioural model of software-visible receive state
  logic       m_ren, m_rf, m_r9;
  logic [7:0] m_buf;
  logic [7:0] tx_q[$];

  mcu_serial_port i_mcu_serial_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_tick(timer_tick),
    .rate_hi(rate_hi), .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe), .txd(txd)
  );

  initial begin
    timer_tick = 1'b0;
    forever begin
      repeat (TT-1) @(negedge clk);
      timer_tick = 1'b1;
      @(negedge clk);
      timer_tick = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    bus_addr = a; #1; v = bus_rdata; bus_addr = 1'b0;
  endtask

  task automatic model_frame(input logic [7:0] d, input logic n9);
    if (m_ren && !m_rf) begin m_rf = 1'b1; m_buf = d; m_r9 = n9; end
  endtask

  task automatic chk_rx(input string tag);
    logic [7:0] c, b;
    rd(1'b0, c); rd(1'b1, b);
    chk({tag, " rx flag"}, c[0], m_rf);
    chk({tag, " rx ninth"}, c[2], m_r9);
    chk({tag, " rx byte"}, b, m_buf);
  endtask

  task automatic send_async(input logic [8:0] v, input int nd);
    rxd_in = 1'b0;
    repeat (BC) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      rxd_in = v[i];
      repeat (BC) @(negedge clk);
    end
    rxd_in = 1'b1;
    repeat (BC) @(negedge clk);
  endtask

  task automatic decode_async(input int nb, output logic [10:0] fr,
                              output logic tf_pre, output logic tf_stop);
    logic [7:0] c;
    fr = '0; tf_pre = 1'b0; tf_stop = 1'b0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (BC/2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      if (i > 0) repeat (BC) @(negedge clk);
      fr[i] = txd;
      rd(1'b0, c);
      if (i == nb-2) tf_pre = c[1];
      if (i == nb-1) tf_stop = c[1];
    end
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (txd !== 1'b0) @(negedge clk);
    while (txd === 1'b0 && n < 2000) begin @(negedge clk); n++; end
  endtask

  logic [7:0]  c, b, exp_b;
  logic [10:0] fr;
  logic        tp, ts, prev, oe_ok;
  int          n, t, t1, t2, got;

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    rate_hi = 1'b1; rxd_in = 1'b1;
    m_ren = 1'b0; m_rf = 1'b0; m_r9 = 1'b0; m_buf = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(1'b0, c); chk("R1 ctrl", c, 8'h00);
    rd(1'b1, b); chk("R1 rx byte", b, 8'h00);
    chk("R1 txd", txd, 1'b1);
    chk("R1 rxd_oe", rxd_oe, 1'b0);

    // R5 mode 1 transmit, R13 flag timing
    wr(1'b0, 8'h50); m_ren = 1'b1;
    tx_q.push_back(8'hA5);
    wr(1'b1, 8'hA5);
    decode_async(10, fr, tp, ts);
    exp_b = tx_q.pop_front();
    chk("R5 start bit", fr[0], 1'b0);
    chk("R5 data", fr[8:1], exp_b);
    chk("R5 stop bit", fr[9], 1'b1);
    chk("R13 flag low in last data bit", tp, 1'b0);
    chk("R13 flag set in stop bit", ts, 1'b1);
    wr(1'b0, 8'h50);
    rd(1'b0, c); chk("R2 flag cleared by write", c[1], 1'b0);

    // R7 mode 1 receive: stop bit goes to receive ninth
    send_async(9'h03C, 8); model_frame(8'h3C, 1'b1);
    repeat (4) @(negedge clk);
    chk_rx("R7 mode1");

    // R11 overrun: second frame dropped while flag set
    wr(1'b0, 8'h54);  // keep ninth bit at 1, flags untouched by writing 0? clear-only: bit0=0 clears
    m_rf = 1'b0; m_r9 = 1'b1;
    send_async(9'h000, 8); model_frame(8'h00, 1'b1);
    repeat (4) @(negedge clk);
    wr(1'b0, 8'h55); m_r9 = 1'b1;
    send_async(9'h155, 8); model_frame(8'h55, 1'b0);
    repeat (4) @(negedge clk);
    chk_rx("R11 overrun");

    // R9 receive disabled
    wr(1'b0, 8'h40); m_ren = 1'b0; m_rf = 1'b0; m_r9 = 1'b0;
    send_async(9'h011, 8); model_frame(8'h11, 1'b1);
    repeat (4) @(negedge clk);
    chk_rx("R9 disabled");

    // R10 false start, then a good frame
    wr(1'b0, 8'h50); m_ren = 1'b1;
    rxd_in = 1'b0; repeat (15) @(negedge clk); rxd_in = 1'b1;
    repeat (2*BC) @(negedge clk);
    chk_rx("R10 glitch ignored");
    send_async(9'h181, 8); model_frame(8'h81, 1'b1);
    repeat (4) @(negedge clk);
    chk_rx("R10 recovery");
    wr(1'b0, 8'h50); m_rf = 1'b0; m_r9 = 1'b0;

    // R12 full duplex with separate buffers
    tx_q.push_back(8'h5A);
    wr(1'b1, 8'h5A);
    fork
      decode_async(10, fr, tp, ts);
      send_async(9'h1E7, 8);
    join
    model_frame(8'hE7, 1'b1);
    repeat (4) @(negedge clk);
    exp_b = tx_q.pop_front();
    chk("R12 tx data during rx", fr[8:1], exp_b);
    chk_rx("R12 rx data during tx");

    // R6/R7 mode 3, ninth bits; R2 readback
    wr(1'b0, 8'hDC); m_rf = 1'b0; m_r9 = 1'b1;
    rd(1'b0, c); chk("R2 ctrl readback", c, 8'hDC);
    tx_q.push_back(8'h33);
    wr(1'b1, 8'h33);
    decode_async(11, fr, tp, ts);
    exp_b = tx_q.pop_front();
    chk("R6 data", fr[8:1], exp_b);
    chk("R6 ninth bit from ctrl", fr[9], 1'b1);
    chk("R6 stop bit", fr[10], 1'b1);
    chk("R13 mode3 flag in stop", {tp, ts}, 2'b01);
    send_async(9'h0C6, 9); model_frame(8'hC6, 1'b0);
    repeat (4) @(negedge clk);
    chk_rx("R7 mode3 ninth 0");
    wr(1'b0, 8'hD0); m_rf = 1'b0; m_r9 = 1'b0;
    send_async(9'h129, 9); model_frame(8'h29, 1'b1);
    repeat (4) @(negedge clk);
    chk_rx("R7 mode3 ninth 1");

    // R8 mode 2 rate
    wr(1'b0, 8'h88); rate_hi = 1'b1;
    wr(1'b1, 8'h00);
    measure_low(n);
    chk("R8 div32 nine low bits", (n >= 280 && n <= 292), 1'b1);
    repeat (3*32) @(negedge clk);
    rate_hi = 1'b0;
    wr(1'b1, 8'h00);
    measure_low(n);
    chk("R8 div64 nine low bits", (n >= 566 && n <= 582), 1'b1);
    repeat (3*64) @(negedge clk);

    // R3 mode 0 transmit
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h96);
    prev = txd; got = 0; t = 0; t1 = 0; t2 = 0; b = '0; oe_ok = 1'b1;
    while (got < 8 && t < 400) begin
      @(negedge clk); t++;
      if (!prev && txd) begin
        b[got] = rxd_out; oe_ok &= rxd_oe;
        if (got == 0) t1 = t;
        if (got == 1) t2 = t;
        got++;
      end
      prev = txd;
    end
    chk("R3 shifted byte", b, 8'h96);
    chk("R3 output enabled", oe_ok, 1'b1);
    chk("R3 clock period", t2 - t1, 12);
    repeat (12) @(negedge clk);
    rd(1'b0, c); chk("R3 transmit flag", c[1], 1'b1);
    chk("R3 line released", {rxd_oe, txd}, 2'b01);

    // R4 mode 0 receive
    wr(1'b0, 8'h10);
    exp_b = 8'hC3; prev = 1'b1; got = 0; t = 0;
    while (got < 8 && t < 400) begin
      @(negedge clk); t++;
      if (prev && !txd) begin rxd_in = exp_b[got]; got++; end
      prev = txd;
    end
    repeat (16) @(negedge clk);
    rxd_in = 1'b1;
    rd(1'b0, c); rd(1'b1, b);
    chk("R4 rx flag", c[0], 1'b1);
    chk("R4 rx byte", b, exp_b);
    n = 0;
    repeat (30) begin @(negedge clk); if (!txd) n++; end
    chk("R4 no clock while flag set", n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule